// File: doc/BRIEF.md
# Aliased Floating-Point / Packed-Integer Register File

This block holds eight 80-bit registers in a single storage array and gives two views of them. In the floating-point view the registers form a circular stack. A 3-bit top pointer selects the stack top, and a stack-relative slot number `i` names physical register `(top + i) mod 8`. In the packed-integer view the same registers are 64 bits wide and are selected directly by a 3-bit number, with no reference to the top pointer. A 16-bit tag word holds a 2-bit state for each physical register, so the storage can be checked without decoding its contents.

One operation is accepted per cycle. Its effects on the tags, the top pointer, the mode and the flags are visible on the outputs after the clock edge that samples it. Read data also appears after that edge, together with a one-cycle `rd_valid` strobe. The block itself switches between the two views. The first packed operation that follows floating-point activity enters packed mode, marks every register valid and clears the top pointer. Any floating-point operation leaves packed mode. A packed write forces the upper 16 bits of its register to all ones, so the packed value reads as a NaN or infinity in the floating-point view.

Top module: `fpx_regfile`

## Requirements
- R1: After reset the tag word is 16'hFFFF (all empty), the top pointer is 0, packed mode is off and both stack flags are low.
- R2: A push (op 1) onto an empty slot decrements the top pointer modulo 8 and writes the data at the new top. A pop (op 2) of a non-empty top returns that register on `rd_data` with `rd_valid` high, tags it empty and increments the top pointer.
- R3: A push whose target register (top-1 mod 8) is not empty raises `stk_over` for one cycle and changes neither the storage, the tags nor the top pointer.
- R4: A pop of an empty top raises `stk_under` for one cycle and leaves the top pointer unchanged. A stack read (op 4) of an empty slot also raises `stk_under`.
- R5: Tags use 00 valid, 01 zero, 10 special and 11 empty, and physical register p occupies tag_word[2p+1:2p]. A floating-point write tags the value zero when exponent (bits 78:64) and mantissa (bits 63:0) are both zero. It tags the value special when the exponent is all ones, or when the exponent is zero and the mantissa is nonzero. Any other value is tagged valid.
- R6: A stack write (op 3) and a stack read (op 4) with slot i address physical register (top + i) mod 8.
- R7: A packed write (op 5) or packed read (op 6) issued while packed mode is off sets packed mode, sets the tag word to 16'h0000 and sets the top pointer to 0.
- R8: A packed write stores {16'hFFFF, data[63:0]} in the directly numbered register and tags it valid. A packed read returns that register's full 80 bits, whatever the top pointer holds.
- R9: The empty-all command (op 7) sets the tag word to 16'hFFFF, turns packed mode off and leaves the top pointer unchanged.
- R10: Any stack operation (ops 1 to 4) turns packed mode off and does not rewrite the tag word as a whole.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | 0 none, 1 push, 2 pop, 3 stack write, 4 stack read, 5 packed write, 6 packed read, 7 empty all |
| op_idx | input | 3 | Stack slot (ops 3, 4) or direct register number (ops 5, 6) |
| wdata | input | 80 | Write data; packed writes use bits 63:0 |
| rd_data | output | 80 | Read result of pop, stack read or packed read |
| rd_valid | output | 1 | One-cycle strobe with new `rd_data` |
| top_ptr | output | 3 | Stack top pointer |
| tag_word | output | 16 | Two tag bits per physical register |
| packed_mode | output | 1 | High while in packed view |
| stk_over | output | 1 | One-cycle stack overflow pulse |
| stk_under | output | 1 | One-cycle stack underflow pulse |

## Verification
The stack is first tried with pushes of a normal number, a zero, an infinity and a denormal, which separates the three value tags. It is then filled with eight distinct values and pushed once more, so that the lost write and the unmoved pointer both become visible. Stack reads at several slot numbers with a nonzero top show whether addressing is relative. Reading a packed register after a push, and reading a packed register through the stack view, shows that both views share storage, that the pointer is reset on entry and that the forced exponent bits are stored.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PUSH   = 3'd1,
    OP_POP    = 3'd2,
    OP_FSTORE = 3'd3,
    OP_FLOAD  = 3'd4,
    OP_PWRITE = 3'd5,
    OP_PREAD  = 3'd6,
    OP_EMPTY  = 3'd7
  } fpx_op_e;

  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } fpx_tag_e;

endpackage

// File: rtl/fpx_tag_classify.sv
module fpx_tag_classify #(
  parameter int MANT_W = 64,
  parameter int EXP_W  = 15
) (
  input  logic [MANT_W+EXP_W:0] value_i,
  output logic [1:0]            tag_o
);
  import fpx_pkg::*;

  logic [EXP_W-1:0]  exp_f;
  logic [MANT_W-1:0] man_f;
  logic              exp_ones;
  logic              exp_zero;
  logic              man_zero;

  always_comb begin
    exp_f    = value_i[MANT_W +: EXP_W];
    man_f    = value_i[MANT_W-1:0];
    exp_ones = &exp_f;
    exp_zero = ~|exp_f;
    man_zero = ~|man_f;
    if (exp_zero && man_zero)
      tag_o = TAG_ZERO;
    else if (exp_ones || (exp_zero && !man_zero))
      tag_o = TAG_SPECIAL;
    else
      tag_o = TAG_VALID;
  end
endmodule

// File: rtl/fpx_reg_array.sv
module fpx_reg_array #(
  parameter int NREG  = 8,
  parameter int REG_W = 80
) (
  input  logic                    clk,
  input  logic                    we_i,
  input  logic [$clog2(NREG)-1:0] waddr_i,
  input  logic [REG_W-1:0]        wdata_i,
  input  logic [$clog2(NREG)-1:0] raddr_i,
  output logic [REG_W-1:0]        rdata_o
);
  logic [REG_W-1:0] row_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_row
    logic row_en;
    always_comb row_en = we_i && (waddr_i == g[$clog2(NREG)-1:0]);
    always_ff @(posedge clk) begin
      if (row_en) row_q[g] <= wdata_i;
    end
  end

  always_comb rdata_o = row_q[raddr_i];
endmodule

// File: rtl/fpx_tag_file.sv
module fpx_tag_file #(
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    all_en_i,
  input  logic [1:0]              all_val_i,
  input  logic                    wr_en_i,
  input  logic [$clog2(NREG)-1:0] wr_idx_i,
  input  logic [1:0]              wr_val_i,
  output logic [2*NREG-1:0]       tags_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_tag
    logic [1:0] tag_q;
    logic [1:0] tag_d;
    logic       tag_en;
    logic       hit;

    always_comb begin
      hit    = wr_en_i && (wr_idx_i == g[$clog2(NREG)-1:0]);
      tag_en = all_en_i || hit;
      tag_d  = hit ? wr_val_i : all_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tag_q <= 2'b11;
      else if (tag_en) tag_q <= tag_d;
    end

    always_comb tags_o[2*g +: 2] = tag_q;
  end
endmodule

// File: rtl/fpx_regfile.sv
module fpx_regfile #(
  parameter int NREG   = 8,
  parameter int MANT_W = 64,
  parameter int EXP_W  = 15
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          op_valid,
  input  logic [2:0]                    op_code,
  input  logic [$clog2(NREG)-1:0]       op_idx,
  input  logic [MANT_W+EXP_W:0]         wdata,
  output logic [MANT_W+EXP_W:0]         rd_data,
  output logic                          rd_valid,
  output logic [$clog2(NREG)-1:0]       top_ptr,
  output logic [2*NREG-1:0]             tag_word,
  output logic                          packed_mode,
  output logic                          stk_over,
  output logic                          stk_under
);
  import fpx_pkg::*;

  localparam int REG_W = MANT_W + EXP_W + 1;
  localparam int PTR_W = $clog2(NREG);
  localparam int HI_W  = REG_W - MANT_W;

  // state registers
  logic [PTR_W-1:0] top_q, top_d;
  logic             top_en;
  logic             pk_q, pk_d;
  logic             pk_en;
  logic             over_q, over_d;
  logic             under_q, under_d;
  logic [REG_W-1:0] rd_q;
  logic             rd_en;
  logic             rdv_q;

  // datapath wires
  logic             arr_we;
  logic [PTR_W-1:0] arr_waddr;
  logic [REG_W-1:0] arr_wdata;
  logic [PTR_W-1:0] arr_raddr;
  logic [REG_W-1:0] arr_rdata;
  logic [1:0]       wr_class;
  logic             tag_all_en;
  logic [1:0]       tag_all_val;
  logic             tag_wr_en;
  logic [PTR_W-1:0] tag_wr_idx;
  logic [1:0]       tag_wr_val;
  logic [2*NREG-1:0] tags;

  logic             is_fp;
  logic             is_pk;
  logic [PTR_W-1:0] push_slot;
  logic [PTR_W-1:0] rel_slot;
  logic [1:0]       tag_push;
  logic [1:0]       tag_top;
  logic [1:0]       tag_rel;

  fpx_tag_classify #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_class (
    .value_i (wdata),
    .tag_o   (wr_class)
  );

  fpx_reg_array #(.NREG(NREG), .REG_W(REG_W)) u_array (
    .clk     (clk),
    .we_i    (arr_we),
    .waddr_i (arr_waddr),
    .wdata_i (arr_wdata),
    .raddr_i (arr_raddr),
    .rdata_o (arr_rdata)
  );

  fpx_tag_file #(.NREG(NREG)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .all_en_i  (tag_all_en),
    .all_val_i (tag_all_val),
    .wr_en_i   (tag_wr_en),
    .wr_idx_i  (tag_wr_idx),
    .wr_val_i  (tag_wr_val),
    .tags_o    (tags)
  );

  // operation decode and addressing
  always_comb begin
    is_fp = op_valid && (op_code == OP_PUSH  || op_code == OP_POP ||
                         op_code == OP_FSTORE || op_code == OP_FLOAD);
    is_pk = op_valid && (op_code == OP_PWRITE || op_code == OP_PREAD);
    push_slot = top_q - PTR_W'(1);
    rel_slot  = top_q + op_idx;
    tag_push  = tags[2*push_slot +: 2];
    tag_top   = tags[2*top_q +: 2];
    tag_rel   = tags[2*rel_slot +: 2];
  end

  // next-state logic
  always_comb begin
    arr_we      = 1'b0;
    arr_waddr   = op_idx;
    arr_wdata   = wdata;
    arr_raddr   = op_idx;
    tag_all_en  = 1'b0;
    tag_all_val = TAG_EMPTY;
    tag_wr_en   = 1'b0;
    tag_wr_idx  = op_idx;
    tag_wr_val  = wr_class;
    top_en      = 1'b0;
    top_d       = top_q;
    pk_en       = 1'b0;
    pk_d        = pk_q;
    over_d      = 1'b0;
    under_d     = 1'b0;
    rd_en       = 1'b0;

    if (is_fp) begin
      pk_en = 1'b1;
      pk_d  = 1'b0;
    end

    if (is_pk && !pk_q) begin
      pk_en       = 1'b1;
      pk_d        = 1'b1;
      top_en      = 1'b1;
      top_d       = '0;
      tag_all_en  = 1'b1;
      tag_all_val = TAG_VALID;
    end

    if (op_valid) begin
      unique case (op_code)
        OP_PUSH: begin
          if (tag_push == TAG_EMPTY) begin
            arr_we     = 1'b1;
            arr_waddr  = push_slot;
            tag_wr_en  = 1'b1;
            tag_wr_idx = push_slot;
            top_en     = 1'b1;
            top_d      = push_slot;
          end else begin
            over_d = 1'b1;
          end
        end
        OP_POP: begin
          arr_raddr = top_q;
          if (tag_top != TAG_EMPTY) begin
            rd_en      = 1'b1;
            tag_wr_en  = 1'b1;
            tag_wr_idx = top_q;
            tag_wr_val = TAG_EMPTY;
            top_en     = 1'b1;
            top_d      = top_q + PTR_W'(1);
          end else begin
            under_d = 1'b1;
          end
        end
        OP_FSTORE: begin
          arr_we     = 1'b1;
          arr_waddr  = rel_slot;
          tag_wr_en  = 1'b1;
          tag_wr_idx = rel_slot;
        end
        OP_FLOAD: begin
          arr_raddr = rel_slot;
          rd_en     = 1'b1;
          under_d   = (tag_rel == TAG_EMPTY);
        end
        OP_PWRITE: begin
          arr_we     = 1'b1;
          arr_wdata  = {{HI_W{1'b1}}, wdata[MANT_W-1:0]};
          tag_wr_en  = 1'b1;
          tag_wr_val = TAG_VALID;
        end
        OP_PREAD: begin
          rd_en = 1'b1;
        end
        OP_EMPTY: begin
          tag_all_en  = 1'b1;
          tag_all_val = TAG_EMPTY;
          pk_en       = 1'b1;
          pk_d        = 1'b0;
        end
        default: begin
        end
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q   <= '0;
      pk_q    <= 1'b0;
      over_q  <= 1'b0;
      under_q <= 1'b0;
      rdv_q   <= 1'b0;
    end else begin
      if (top_en) top_q <= top_d;
      if (pk_en)  pk_q  <= pk_d;
      over_q  <= over_d;
      under_q <= under_d;
      rdv_q   <= rd_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= arr_rdata;
  end

  always_comb begin
    rd_data     = rd_q;
    rd_valid    = rdv_q;
    top_ptr     = top_q;
    tag_word    = tags;
    packed_mode = pk_q;
    stk_over    = over_q;
    stk_under   = under_q;
  end
endmodule

// File: rtl/fpx_regfile_chk.sv
module fpx_regfile_chk #(
  parameter int NREG = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    op_valid,
  input logic [2:0]              op_code,
  input logic [$clog2(NREG)-1:0] top_ptr,
  input logic [2*NREG-1:0]       tag_word,
  input logic                    packed_mode,
  input logic                    stk_over,
  input logic                    stk_under
);
  import fpx_pkg::*;
  localparam int PTR_W = $clog2(NREG);

  logic [PTR_W-1:0] nxt_top;
  logic [1:0]       tag_nxt;
  logic [1:0]       tag_cur;
  logic             do_push;
  logic             do_pop;
  logic             do_fp;
  logic             do_pk;

  always_comb begin
    nxt_top = top_ptr - PTR_W'(1);
    tag_nxt = tag_word[2*nxt_top +: 2];
    tag_cur = tag_word[2*top_ptr +: 2];
    do_push = op_valid && op_code == OP_PUSH;
    do_pop  = op_valid && op_code == OP_POP;
    do_fp   = op_valid && op_code >= OP_PUSH && op_code <= OP_FLOAD;
    do_pk   = op_valid && (op_code == OP_PWRITE || op_code == OP_PREAD);
  end

  p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    do_push && tag_nxt == TAG_EMPTY |=> top_ptr == $past(nxt_top));

  p_pop_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop && tag_cur != TAG_EMPTY |=> tag_word[2*$past(top_ptr) +: 2] == TAG_EMPTY);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    do_push && tag_nxt != TAG_EMPTY |=> stk_over && $stable(top_ptr) && $stable(tag_word));

  p_over_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stk_over |-> $past(do_push));

  p_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop && tag_cur == TAG_EMPTY |=> stk_under && $stable(top_ptr));

  p_packed_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    do_pk && !packed_mode |=> packed_mode && top_ptr == '0 && tag_word == '0);

  p_empty_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_EMPTY |=> tag_word == '1 && !packed_mode && $stable(top_ptr));

  p_fp_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    do_fp |=> !packed_mode);

  p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stk_over, stk_under}));
endmodule

bind fpx_regfile fpx_regfile_chk #(.NREG(NREG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid    (op_valid),
  .op_code     (op_code),
  .top_ptr     (top_ptr),
  .tag_word    (tag_word),
  .packed_mode (packed_mode),
  .stk_over    (stk_over),
  .stk_under   (stk_under)
);

// File: tb/fpx_regfile_bench.sv
module fpx_regfile_bench;
  import fpx_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [2:0]  op_idx;
  logic [79:0] wdata;
  logic [79:0] rd_data;
  logic        rd_valid;
  logic [2:0]  top_ptr;
  logic [15:0] tag_word;
  logic        packed_mode;
  logic        stk_over;
  logic        stk_under;

  int n_chk;
  int n_fail;
  bit done;

  localparam logic [79:0] V_NORM = {16'h3FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] V_ZERO = 80'h0;
  localparam logic [79:0] V_INF  = {16'h7FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] V_DEN  = 80'h1;
  localparam logic [63:0] P_VAL  = 64'h0123_4567_89AB_CDEF;

  fpx_regfile u_fpx_regfile (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_idx(op_idx), .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .top_ptr(top_ptr), .tag_word(tag_word), .packed_mode(packed_mode),
    .stk_over(stk_over), .stk_under(stk_under)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input fpx_op_e c, input logic [2:0] i, input logic [79:0] d);
    @(negedge clk);
    op_valid = 1'b1;
    op_code  = c;
    op_idx   = i;
    wdata    = d;
    @(posedge clk);
    #1;
    op_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 tags", 80'(tag_word), 80'hFFFF);
    chk("R1 top", 80'(top_ptr), 80'd0);
    chk("R1 mode", 80'(packed_mode), 80'd0);
    chk("R1 flags", 80'({stk_over, stk_under}), 80'd0);
  endtask

  task automatic t_push_classes;
    apply(OP_PUSH, 3'd0, V_NORM);
    chk("R2 top after push", 80'(top_ptr), 80'd7);
    chk("R5 valid tag", 80'(tag_word), 80'h3FFF);
    apply(OP_PUSH, 3'd0, V_ZERO);
    chk("R5 zero tag", 80'(tag_word), 80'h1FFF);
    apply(OP_PUSH, 3'd0, V_INF);
    chk("R5 inf special tag", 80'(tag_word), 80'h1BFF);
    apply(OP_PUSH, 3'd0, V_DEN);
    chk("R5 denormal special tag", 80'(tag_word), 80'h1AFF);
    chk("R2 top after four pushes", 80'(top_ptr), 80'd4);
  endtask

  task automatic t_relative;
    apply(OP_FLOAD, 3'd3, '0);
    chk("R6 read slot 3", rd_data, V_NORM);
    chk("R6 rd_valid", 80'(rd_valid), 80'd1);
    apply(OP_FLOAD, 3'd1, '0);
    chk("R6 read slot 1", rd_data, V_INF);
    apply(OP_FSTORE, 3'd0, V_ZERO);
    chk("R6 store slot 0 retags", 80'(tag_word), 80'h19FF);
  endtask

  task automatic t_pop_underflow;
    apply(OP_POP, 3'd0, '0);
    chk("R2 pop data", rd_data, V_ZERO);
    chk("R2 pop top", 80'(top_ptr), 80'd5);
    chk("R2 pop tag", 80'(tag_word), 80'h1BFF);
    apply(OP_FLOAD, 3'd5, '0);
    chk("R4 read of empty slot", 80'(stk_under), 80'd1);
    apply(OP_POP, 3'd0, '0);
    chk("R2 pop inf", rd_data, V_INF);
    chk("R4 flag clears", 80'(stk_under), 80'd0);
    apply(OP_POP, 3'd0, '0);
    chk("R2 pop zero", rd_data, V_ZERO);
    apply(OP_POP, 3'd0, '0);
    chk("R2 pop norm", rd_data, V_NORM);
    chk("R2 wrap top", 80'(top_ptr), 80'd0);
    chk("R2 all empty", 80'(tag_word), 80'hFFFF);
    apply(OP_POP, 3'd0, '0);
    chk("R4 pop empty flag", 80'(stk_under), 80'd1);
    chk("R4 pop empty top", 80'(top_ptr), 80'd0);
  endtask

  task automatic t_overflow;
    for (int k = 0; k < 8; k++) apply(OP_PUSH, 3'd0, {16'h4000, 64'(k)});
    chk("R2 full stack tags", 80'(tag_word), 80'h0000);
    chk("R2 full stack top", 80'(top_ptr), 80'd0);
    chk("R3 no flag before full", 80'(stk_over), 80'd0);
    apply(OP_PUSH, 3'd0, {16'h4000, 64'hDEAD});
    chk("R3 overflow flag", 80'(stk_over), 80'd1);
    chk("R3 top held", 80'(top_ptr), 80'd0);
    apply(OP_FLOAD, 3'd7, '0);
    chk("R3 oldest kept", rd_data, {16'h4000, 64'd0});
    apply(OP_FLOAD, 3'd0, '0);
    chk("R3 top value kept", rd_data, {16'h4000, 64'd7});
    chk("R3 flag clears", 80'(stk_over), 80'd0);
  endtask

  task automatic t_packed;
    apply(OP_EMPTY, 3'd0, '0);
    chk("R9 tags empty", 80'(tag_word), 80'hFFFF);
    chk("R9 top kept", 80'(top_ptr), 80'd0);
    apply(OP_PUSH, 3'd0, V_NORM);
    chk("R2 push after empty", 80'(top_ptr), 80'd7);
    apply(OP_PWRITE, 3'd3, {16'h0, P_VAL});
    chk("R7 mode set", 80'(packed_mode), 80'd1);
    chk("R7 top cleared", 80'(top_ptr), 80'd0);
    chk("R7 tags valid", 80'(tag_word), 80'h0000);
    apply(OP_PREAD, 3'd3, '0);
    chk("R8 forced exponent", rd_data, {16'hFFFF, P_VAL});
    apply(OP_PREAD, 3'd7, '0);
    chk("R8 direct address", rd_data, V_NORM);
    apply(OP_FLOAD, 3'd3, '0);
    chk("R10 alias via stack", rd_data, {16'hFFFF, P_VAL});
    chk("R10 mode off", 80'(packed_mode), 80'd0);
    chk("R10 tags kept", 80'(tag_word), 80'h0000);
    chk("R10 no underflow", 80'(stk_under), 80'd0);
  endtask

  task automatic t_empty_in_packed;
    apply(OP_PWRITE, 3'd0, {16'h0, P_VAL});
    chk("R7 reentry", 80'(packed_mode), 80'd1);
    apply(OP_EMPTY, 3'd0, '0);
    chk("R9 leaves packed", 80'(packed_mode), 80'd0);
    chk("R9 tags empty again", 80'(tag_word), 80'hFFFF);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    done = 1'b0;
    op_valid = 1'b0;
    op_code = 3'd0;
    op_idx = 3'd0;
    wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_push_classes();
    t_relative();
    t_pop_underflow();
    t_overflow();
    t_packed();
    t_empty_in_packed();
    done = 1'b1;
    finish_run();
  end
endmodule